// File: doc/BRIEF.md
# Guest-to-Shadow Root Pointer Cache

This block sits beside the translation root register of a virtualized core. When a guest operating system switches address spaces it writes a new guest root-pointer value. Hardware uses that value to look in a small, fully associative table of pairs, each mapping a guest root value to the shadow root value the hypervisor built for it. On a hit, the shadow root register is loaded directly and the context switch completes with no exit to the hypervisor. On a miss, the block raises a one-cycle trap request so that the hypervisor can take over.

The hypervisor alone changes the table's contents. It installs pairs through a fill port, removes a single pair by its guest root value through an invalidate port, and empties the whole table with a flush input. A fill whose guest root is already present replaces that entry's shadow value. Otherwise the fill takes the slot named by a round-robin victim pointer.

Top module: `g2s_root_cache`

## Requirements
- R1: A lookup that matches a valid entry yields, in the next cycle, `rsp_hit`=1 and `trap_req`=0, and `shadow_root` is loaded with that entry's shadow value.
- R2: A lookup that matches no valid entry yields, in the next cycle, `trap_req`=1 and `rsp_hit`=0. `shadow_root` keeps its previous value.
- R3: In a cycle after one with no lookup, `rsp_hit` and `trap_req` are both 0 and `shadow_root` holds its value.
- R4: A fill whose guest root is not present writes the slot at the victim pointer and advances the pointer by one, modulo 8. The pointer starts at slot 0, so the ninth distinct fill evicts the first.
- R5: A fill whose guest root is already present overwrites that entry's shadow value in place. It neither allocates a new slot nor moves the victim pointer.
- R6: An invalidate removes only the entry whose guest root equals the given value. An invalidate that matches nothing changes nothing.
- R7: Flush clears every entry and returns the victim pointer to slot 0. It overrides any fill or invalidate in the same cycle.
- R8: A lookup in the same cycle as a fill or an invalidate sees the table as it was before that cycle.
- R9: After reset, every entry is empty, `shadow_root` is 0, and `rsp_hit` and `trap_req` are 0.
- R10: When a fill and an invalidate occur in the same cycle, the invalidate is applied first and the fill second. A fill and an invalidate with the same guest root therefore leave that key present with the filled value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Guest root change, lookup request |
| lkp_groot | input | GROOT_W | New guest root value |
| fill_valid | input | 1 | Hypervisor installs a pair |
| fill_groot | input | GROOT_W | Guest root of the pair |
| fill_sroot | input | SROOT_W | Shadow root of the pair |
| inval_valid | input | 1 | Hypervisor removes one pair |
| inval_groot | input | GROOT_W | Guest root to remove |
| flush_all | input | 1 | Clear every entry |
| rsp_hit | output | 1 | Lookup hit, one cycle after the request |
| trap_req | output | 1 | Lookup miss, hypervisor trap request |
| shadow_root | output | SROOT_W | Shadow root register |

## Verification
The bench fills past capacity so that the victim pointer wraps. A design with an off-by-one wrap would evict the wrong slot and hit where a miss is expected. It overwrites an existing key and then allocates. A design that advanced the pointer on overwrite, or stored a duplicate, would evict a neighbouring key or return a stale shadow value. It also issues lookups in the same cycle as fills, invalidates and flushes, and issues fills in the same cycle as invalidates and flushes. Wrong write-before-read ordering or wrong priority shows up there as a hit or miss flipped in one cycle.

// File: rtl/g2s_pkg.sv
// Package g2s_pkg
// Shared types for the guest-to-shadow root cache.
package g2s_pkg;
    // Outcome of the fill port in one cycle.
    typedef enum logic [1:0] {
        FILL_NONE      = 2'd0,
        FILL_OVERWRITE = 2'd1,
        FILL_ALLOCATE  = 2'd2
    } fill_act_e;
endpackage

// File: rtl/g2s_match.sv
// Module g2s_match
// Compares one probe key against every stored guest root in parallel and
// returns the vector of valid entries that match.
// Assumes the store never holds the same key twice, so the vector is one-hot or zero.
module g2s_match #(
    parameter int ENTRIES = 8,
    parameter int GROOT_W = 32
) (
    input  logic [ENTRIES-1:0]              ent_valid,
    input  logic [ENTRIES-1:0][GROOT_W-1:0] ent_groot,
    input  logic [GROOT_W-1:0]              probe,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic                            any_hit
);
    // One comparator per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_groot[i] == probe);
    end

    // Reduce the per-entry matches to a single hit flag.
    assign any_hit = |hit_vec;
endmodule

// File: rtl/g2s_onehot_enc.sv
// Module g2s_onehot_enc
// Turns a one-hot (or zero) vector into a binary slot index.
// Assumes at most one bit is set; a zero vector gives index 0.
module g2s_onehot_enc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] vec,
    output logic [IDX_W-1:0]   idx
);
    // OR together the indices of the set bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/g2s_store.sv
// Module g2s_store
// Holds the entry array and the round-robin victim pointer, and applies
// flush, invalidate and fill.
// Assumes fill_hit and fill_idx come from a match against the current
// (pre-update) contents. Flush wins over everything else. An invalidate is
// applied before a fill in the same cycle.
module g2s_store
    import g2s_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int GROOT_W = 32,
    parameter int SROOT_W = 32,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fill_valid,
    input  logic [GROOT_W-1:0]              fill_groot,
    input  logic [SROOT_W-1:0]              fill_sroot,
    input  logic                            fill_hit,
    input  logic [IDX_W-1:0]                fill_idx,
    input  logic [ENTRIES-1:0]              inval_vec,
    input  logic                            flush,
    output logic [ENTRIES-1:0]              ent_valid,
    output logic [ENTRIES-1:0][GROOT_W-1:0] ent_groot,
    output logic [ENTRIES-1:0][SROOT_W-1:0] ent_sroot
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

    fill_act_e        fill_act;
    logic [IDX_W-1:0] victim_ptr;
    logic [IDX_W-1:0] tgt_idx;
    logic [ENTRIES-1:0] tgt_vec;

    // Decide whether the fill replaces a present key or allocates a slot.
    always_comb begin
        if (!fill_valid)   fill_act = FILL_NONE;
        else if (fill_hit) fill_act = FILL_OVERWRITE;
        else               fill_act = FILL_ALLOCATE;
    end

    // Choose the slot the fill writes.
    assign tgt_idx = (fill_act == FILL_OVERWRITE) ? fill_idx : victim_ptr;

    // One-hot form of the write slot, zero when there is no fill.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_tgt
        assign tgt_vec[i] = (fill_act != FILL_NONE) && (tgt_idx == IDX_W'(i));
    end

    // Valid bits: reset/flush clear, otherwise invalidate then fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) ent_valid <= '0;
        else                 ent_valid <= (ent_valid & ~inval_vec) | tgt_vec;
    end

    // Key and value storage per slot.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // Write the pair into this slot when it is the fill target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_groot[i] <= '0;
                ent_sroot[i] <= '0;
            end else if (!flush && tgt_vec[i]) begin
                ent_groot[i] <= fill_groot;
                ent_sroot[i] <= fill_sroot;
            end
        end
    end

    // Victim pointer: steps on allocation only, wraps after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) victim_ptr <= '0;
        else if (fill_act == FILL_ALLOCATE)
            victim_ptr <= (victim_ptr == LAST_SLOT) ? '0 : victim_ptr + 1'b1;
    end

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0 && victim_ptr == '0));

    assert_overwrite_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_act == FILL_OVERWRITE && !flush) |=> $stable(victim_ptr));

    assert_no_fill_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_act == FILL_NONE && !flush) |=> ((ent_valid & ~$past(ent_valid)) == '0));
endmodule

// File: rtl/g2s_root_cache.sv
// Module g2s_root_cache
// Top of the guest-to-shadow root cache. A lookup on a guest root change
// answers one cycle later with a hit (loading shadow_root) or a trap request.
// Hypervisor fill, invalidate and flush inputs maintain the table.
// Assumes a lookup compares against the contents before any same-cycle update.
module g2s_root_cache #(
    parameter int ENTRIES = 8,
    parameter int GROOT_W = 32,
    parameter int SROOT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid,
    input  logic [GROOT_W-1:0] lkp_groot,
    input  logic               fill_valid,
    input  logic [GROOT_W-1:0] fill_groot,
    input  logic [SROOT_W-1:0] fill_sroot,
    input  logic               inval_valid,
    input  logic [GROOT_W-1:0] inval_groot,
    input  logic               flush_all,
    output logic               rsp_hit,
    output logic               trap_req,
    output logic [SROOT_W-1:0] shadow_root
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][GROOT_W-1:0] ent_groot;
    logic [ENTRIES-1:0][SROOT_W-1:0] ent_sroot;

    logic [ENTRIES-1:0] lk_vec, fl_vec, iv_vec, iv_gated;
    logic               lk_any, fl_any, iv_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx;

    g2s_match #(.ENTRIES(ENTRIES), .GROOT_W(GROOT_W)) i_match_lkp (
        .ent_valid(ent_valid), .ent_groot(ent_groot), .probe(lkp_groot),
        .hit_vec(lk_vec), .any_hit(lk_any)
    );
    g2s_match #(.ENTRIES(ENTRIES), .GROOT_W(GROOT_W)) i_match_fill (
        .ent_valid(ent_valid), .ent_groot(ent_groot), .probe(fill_groot),
        .hit_vec(fl_vec), .any_hit(fl_any)
    );
    g2s_match #(.ENTRIES(ENTRIES), .GROOT_W(GROOT_W)) i_match_inval (
        .ent_valid(ent_valid), .ent_groot(ent_groot), .probe(inval_groot),
        .hit_vec(iv_vec), .any_hit(iv_any)
    );

    g2s_onehot_enc #(.ENTRIES(ENTRIES)) i_enc_lkp  (.vec(lk_vec), .idx(lk_idx));
    g2s_onehot_enc #(.ENTRIES(ENTRIES)) i_enc_fill (.vec(fl_vec), .idx(fl_idx));

    // Invalidate acts only when requested.
    assign iv_gated = inval_valid ? iv_vec : '0;

    g2s_store #(.ENTRIES(ENTRIES), .GROOT_W(GROOT_W), .SROOT_W(SROOT_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_groot(fill_groot), .fill_sroot(fill_sroot),
        .fill_hit(fl_any), .fill_idx(fl_idx),
        .inval_vec(iv_gated), .flush(flush_all),
        .ent_valid(ent_valid), .ent_groot(ent_groot), .ent_sroot(ent_sroot)
    );

    // Register the lookup outcome and load the shadow root on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit     <= 1'b0;
            trap_req    <= 1'b0;
            shadow_root <= '0;
        end else begin
            rsp_hit  <= lkp_valid && lk_any;
            trap_req <= lkp_valid && !lk_any;
            if (lkp_valid && lk_any) shadow_root <= ent_sroot[lk_idx];
        end
    end

    assert_unique_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(fl_vec) && $onehot0(iv_vec));

    assert_hit_trap_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && trap_req));

    assert_lookup_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> (rsp_hit || trap_req));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> (!rsp_hit && !trap_req));

    assert_root_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> $stable(shadow_root));

    assert_inval_miss_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_valid && !iv_any && !fill_valid && !flush_all) |=> $stable(ent_valid));
endmodule

// File: tb/test_g2s_root_cache.sv
// Bench for g2s_root_cache: a behavioural table model built from the
// requirements predicts every lookup response; sweeps cover wrap, overwrite,
// invalidate, flush and same-cycle combinations.
module test_g2s_root_cache;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0, fill_valid = 1'b0, inval_valid = 1'b0, flush_all = 1'b0;
    logic [31:0] lkp_groot = '0, fill_groot = '0, fill_sroot = '0, inval_groot = '0;
    logic        rsp_hit, trap_req;
    logic [31:0] shadow_root;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit          m_v [N];
    logic [31:0] m_g [N];
    logic [31:0] m_s [N];
    int          m_ptr = 0;
    logic [31:0] m_sr = '0;

    always #10 clk = ~clk;

    g2s_root_cache i_g2s_root_cache (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_groot(lkp_groot),
        .fill_valid(fill_valid), .fill_groot(fill_groot), .fill_sroot(fill_sroot),
        .inval_valid(inval_valid), .inval_groot(inval_groot),
        .flush_all(flush_all),
        .rsp_hit(rsp_hit), .trap_req(trap_req), .shadow_root(shadow_root)
    );

    function automatic logic [31:0] key(int i);
        return 32'hA000_0000 | (i * 32'h0001_0003);
    endfunction
    function automatic logic [31:0] sval(int i, int salt);
        return 32'h5000_0000 ^ (i * 32'h0000_1111) ^ (salt * 32'h0100_0000);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; model predicts lookup on old contents (R8),
    // then applies flush (R7) or invalidate-then-fill (R10, R4, R5, R6).
    task automatic op(string tag, bit lv, logic [31:0] lk, bit fv, logic [31:0] fk,
                      logic [31:0] fs, bit iv, logic [31:0] ik, bit fl);
        bit found = 0; logic [31:0] es = '0; int fidx = -1;
        lkp_valid = lv; lkp_groot = lk; fill_valid = fv; fill_groot = fk; fill_sroot = fs;
        inval_valid = iv; inval_groot = ik; flush_all = fl;
        for (int i = 0; i < N; i++) if (m_v[i] && m_g[i] == lk) begin found = 1; es = m_s[i]; end
        for (int i = 0; i < N; i++) if (m_v[i] && m_g[i] == fk) fidx = i;
        if (lv && found) m_sr = es;
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (iv) for (int i = 0; i < N; i++) if (m_v[i] && m_g[i] == ik) m_v[i] = 0;
            if (fv) begin
                if (fidx >= 0) begin m_v[fidx] = 1; m_s[fidx] = fs; end
                else begin
                    m_v[m_ptr] = 1; m_g[m_ptr] = fk; m_s[m_ptr] = fs;
                    m_ptr = (m_ptr + 1) % N;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " hit"}, {31'd0, rsp_hit}, {31'd0, lv && found});
        chk({tag, " trap"}, {31'd0, trap_req}, {31'd0, lv && !found});
        chk({tag, " root"}, shadow_root, m_sr);
        lkp_valid = 0; fill_valid = 0; inval_valid = 0; flush_all = 0;
    endtask

    task automatic look(string tag, logic [31:0] k);
        op(tag, 1, k, 0, '0, '0, 0, '0, 0);
    endtask
    task automatic fill(string tag, logic [31:0] k, logic [31:0] s);
        op(tag, 0, '0, 1, k, s, 0, '0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = '0; m_s[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R9: reset state
        chk("R9 hit after reset", {31'd0, rsp_hit}, 32'd0);
        chk("R9 trap after reset", {31'd0, trap_req}, 32'd0);
        chk("R9 root after reset", shadow_root, 32'd0);
        for (int i = 0; i < N; i++) look("R9 empty lookup", key(i));
        op("R3 idle", 0, '0, 0, '0, '0, 0, '0, 0);
        // R1 R4: fill all slots, then hit each
        for (int i = 0; i < N; i++) fill("R4 fill", key(i), sval(i, 0));
        for (int i = 0; i < N; i++) look("R1 hit sweep", key(i));
        look("R2 miss", key(40));
        op("R3 idle after hit", 0, '0, 0, '0, '0, 0, '0, 0);
        // R4: wrap evicts slots 0..2
        for (int i = 8; i < 11; i++) fill("R4 wrap fill", key(i), sval(i, 0));
        for (int i = 0; i < 11; i++) look("R4 wrap sweep", key(i));
        // R5: overwrite in place, pointer stays at slot 3
        fill("R5 overwrite", key(5), sval(5, 7));
        look("R5 new value", key(5));
        fill("R5 next alloc", key(11), sval(11, 0));
        for (int i = 0; i < 12; i++) look("R5 sweep", key(i));
        // R6: invalidate one key; invalidate of unknown key is a no-op
        op("R6 inval", 0, '0, 0, '0, '0, 1, key(6), 0);
        op("R6 inval miss", 0, '0, 0, '0, '0, 1, key(50), 0);
        for (int i = 0; i < 12; i++) look("R6 sweep", key(i));
        // R8: same-cycle lookup sees old contents
        op("R8 fill+lookup", 1, key(12), 1, key(12), sval(12, 0), 0, '0, 0);
        look("R8 after fill", key(12));
        op("R8 inval+lookup", 1, key(7), 0, '0, '0, 1, key(7), 0);
        look("R8 after inval", key(7));
        // R10: invalidate then fill in one cycle
        op("R10 same key", 0, '0, 1, key(8), sval(8, 3), 1, key(8), 0);
        look("R10 same key kept", key(8));
        op("R10 diff keys", 0, '0, 1, key(20), sval(20, 0), 1, key(9), 0);
        look("R10 inval side", key(9));
        look("R10 fill side", key(20));
        // R7: flush beats same-cycle fill, pointer back to 0
        op("R7 flush+fill+lookup", 1, key(20), 1, key(21), sval(21, 0), 1, key(8), 1);
        for (int i = 0; i < 22; i++) look("R7 empty sweep", key(i));
        // R4 R7: refill from slot 0 after flush, over capacity
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < N + 3; i++) fill("R4 refill", key(30 + r * 5 + i), sval(i, r));
            for (int i = 0; i < 45; i++) look("R4 R1 R2 sweep", key(i));
        end
        finish_run();
    end
endmodule